// File: doc/BRIEF.md
# Restricted-Privilege Load/Store Access Unit

This unit turns one decoded load or store micro-op into a single transfer on a 32-bit data bus. The address is a base register value plus an unsigned 8-bit immediate. The unit places byte, halfword or word data on the correct byte lanes. On a load, it zero-extends or sign-extends the returned data to 32 bits. A per-access override input forces the transfer to carry the unprivileged attribute, even while the core runs privileged. With the core already unprivileged, the access is an ordinary immediate-offset access. The unit also rejects register encodings that this class of access may not use, and it rejects misaligned halfword and word addresses. Both rejections are reported in the cycle of the request, and neither starts a bus transfer.

A small state machine sequences each access through four states. `ST_IDLE` accepts a request and moves to `ST_ADDR` when the request is clean. A rejected request stays in `ST_IDLE`. `ST_ADDR` presents the bus request and moves to `ST_RESP` when `bus_ready` is high. `ST_RESP` waits and moves to `ST_DONE` when `bus_rvalid` is high, capturing the load result. `ST_DONE` pulses `done` for one cycle and returns to `ST_IDLE`. The register file, condition evaluation, memory-protection checks and exception entry lie outside the unit, which only reports status to them.

Top module: `user_access_lsu`

## Requirements
- R1: `req_kind` selects the access: 0 is unsigned byte, 1 is signed byte, 2 is unsigned halfword, 3 is signed halfword, 4 is word. For codes 0 and 2, a load zero-extends the addressed byte or halfword of `bus_rdata` into `rdata_out`. For codes 1 and 3, a load sign-extends it. Codes 5 to 7 are illegal encodings.
- R2: A store (`req_store`=1) with kind 1 or 3 is an illegal encoding.
- R3: `bus_addr` equals `req_base` plus the zero-extended `req_imm`, modulo 2^32. An immediate of 0 gives the base unchanged.
- R4: `bus_strb` bit i enables byte lane i (`bus_wdata[8i+7:8i]`). A byte access sets the single lane addressed by `bus_addr[1:0]`. A halfword access sets lanes {0,1} or {2,3}. A word access sets all four. A store replicates the low byte four times for a byte access, the low halfword twice for a halfword access, and sends the full word for a word access. `bus_write` equals `req_store`.
- R5: `bus_priv` (1 = privileged) is 0 when `user_override` was 1 at acceptance. Otherwise it equals `core_priv`.
- R6: A base register index `req_rn` of 15 is an illegal encoding.
- R7: A target register index `req_rt` of 13 or 15 is an illegal encoding.
- R8: An illegal encoding raises `err_illegal` in the request cycle, while `req_valid` is high in `ST_IDLE`. No bus transfer is issued for it.
- R9: For a legal encoding, a halfword at an odd address or a word at an address not a multiple of 4 raises `err_align` in the request cycle. No bus transfer is issued for it.
- R10: `bus_valid` stays high, and the address, strobes and privilege stay stable, until `bus_ready` is high. `done` is a one-cycle pulse in the cycle after `bus_rvalid`, with the load result on `rdata_out`. For a store, `rdata_out` is 0.
- R11: `flag_we` is always 0.
- R12: `req_ready` is high only in `ST_IDLE`, and a completed access returns the unit to `ST_IDLE` in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Micro-op request present |
| req_ready | output | 1 | Unit idle, request may be taken |
| req_store | input | 1 | 1 = store, 0 = load |
| req_kind | input | 3 | Access kind code (R1) |
| req_rn | input | 4 | Base register index |
| req_rt | input | 4 | Target register index |
| req_base | input | 32 | Base register value |
| req_imm | input | 8 | Unsigned immediate offset |
| req_wdata | input | 32 | Store data |
| core_priv | input | 1 | Current core privilege (1 = privileged) |
| user_override | input | 1 | Force unprivileged transfer |
| err_illegal | output | 1 | Illegal encoding, same cycle as request |
| err_align | output | 1 | Misaligned access, same cycle as request |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts request |
| bus_addr | output | 32 | Byte address |
| bus_write | output | 1 | Write transfer |
| bus_strb | output | 4 | Byte lane enables |
| bus_wdata | output | 32 | Lane-replicated write data |
| bus_priv | output | 1 | Transfer privilege attribute (1 = privileged) |
| bus_rvalid | input | 1 | Bus response valid |
| bus_rdata | input | 32 | Bus read data |
| done | output | 1 | Access complete pulse |
| rdata_out | output | 32 | Extended load result |
| flag_we | output | 1 | Condition flag write enable (held low) |

## Verification
The assertions watch several behaviours on every cycle. They check the bus request hold rule while the bus stalls. They check that no request follows a rejected one. They check that an overridden access always leaves as unprivileged, and that the base and target index rules are enforced. They also check that `done` lasts exactly one cycle. The lane positions, the replicated store data, the sign or zero extension of each kind at each offset, and the address carry across the 32-bit wrap are value mappings. Only the bench's sweeps can show these mappings, comparing the bus and result ports against arithmetic expectations.

// File: rtl/uacc_pkg.sv
package uacc_pkg;

    typedef enum logic [2:0] {
        KIND_UBYTE = 3'd0,
        KIND_SBYTE = 3'd1,
        KIND_UHALF = 3'd2,
        KIND_SHALF = 3'd3,
        KIND_WORD  = 3'd4
    } acc_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_RESP = 2'd2,
        ST_DONE = 2'd3
    } lsu_state_e;

endpackage

// File: rtl/uacc_decode_check.sv
module uacc_decode_check
    import uacc_pkg::*;
#(
    parameter int REG_IDX_W = 4,
    parameter int PC_IDX    = 15,
    parameter int SP_IDX    = 13
) (
    input  logic                 is_store,
    input  logic [2:0]           kind,
    input  logic [REG_IDX_W-1:0] rt_idx,
    input  logic [REG_IDX_W-1:0] rn_idx,
    output logic                 illegal,
    output acc_size_e            size,
    output logic                 sign_ext
);

    localparam logic [REG_IDX_W-1:0] PC_CODE = REG_IDX_W'(PC_IDX);
    localparam logic [REG_IDX_W-1:0] SP_CODE = REG_IDX_W'(SP_IDX);

    logic kind_bad;
    logic signed_store;
    logic base_bad;
    logic target_bad;

    always_comb begin
        kind_bad = 1'b0;
        size     = SZ_WORD;
        sign_ext = 1'b0;
        unique case (kind)
            KIND_UBYTE: begin size = SZ_BYTE; sign_ext = 1'b0; end
            KIND_SBYTE: begin size = SZ_BYTE; sign_ext = 1'b1; end
            KIND_UHALF: begin size = SZ_HALF; sign_ext = 1'b0; end
            KIND_SHALF: begin size = SZ_HALF; sign_ext = 1'b1; end
            KIND_WORD:  begin size = SZ_WORD; sign_ext = 1'b0; end
            default:    begin kind_bad = 1'b1; end
        endcase
    end

    assign signed_store = is_store && sign_ext && !kind_bad;
    assign base_bad     = (rn_idx == PC_CODE);
    assign target_bad   = (rt_idx == PC_CODE) || (rt_idx == SP_CODE);
    assign illegal      = kind_bad || signed_store || base_bad || target_bad;

endmodule

// File: rtl/uacc_addr_gen.sv
module uacc_addr_gen
    import uacc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 8
) (
    input  logic [XLEN-1:0]   base,
    input  logic [IMM_W-1:0]  imm,
    input  acc_size_e         size,
    input  logic [XLEN-1:0]   wdata,
    output logic [XLEN-1:0]   addr,
    output logic [XLEN/8-1:0] strb,
    output logic [XLEN-1:0]   lane_wdata,
    output logic              misaligned
);

    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [OFF_W-1:0] off;

    assign addr = base + {{(XLEN-IMM_W){1'b0}}, imm};
    assign off  = addr[OFF_W-1:0];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(i);
        always_comb begin
            unique case (size)
                SZ_BYTE: begin
                    strb[i]            = (off == LANE_IDX);
                    lane_wdata[8*i+:8] = wdata[7:0];
                end
                SZ_HALF: begin
                    strb[i]            = (off[OFF_W-1:1] == LANE_IDX[OFF_W-1:1]);
                    lane_wdata[8*i+:8] = wdata[8*(i%2)+:8];
                end
                default: begin
                    strb[i]            = 1'b1;
                    lane_wdata[8*i+:8] = wdata[8*i+:8];
                end
            endcase
        end
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = off[0];
            default: misaligned = (off != '0);
        endcase
    end

endmodule

// File: rtl/uacc_load_extend.sv
module uacc_load_extend
    import uacc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]          rdata,
    input  logic [$clog2(XLEN/8)-1:0] off,
    input  acc_size_e                size,
    input  logic                     sign_ext,
    output logic [XLEN-1:0]          result
);

    logic [XLEN-1:0] shifted;

    assign shifted = rdata >> {off, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(XLEN-8){sign_ext & shifted[7]}}, shifted[7:0]};
            SZ_HALF: result = {{(XLEN-16){sign_ext & shifted[15]}}, shifted[15:0]};
            default: result = shifted;
        endcase
    end

endmodule

// File: rtl/user_access_lsu.sv
module user_access_lsu
    import uacc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int IMM_W     = 8,
    parameter int REG_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_store,
    input  logic [2:0]           req_kind,
    input  logic [REG_IDX_W-1:0] req_rn,
    input  logic [REG_IDX_W-1:0] req_rt,
    input  logic [XLEN-1:0]      req_base,
    input  logic [IMM_W-1:0]     req_imm,
    input  logic [XLEN-1:0]      req_wdata,
    input  logic                 core_priv,
    input  logic                 user_override,
    output logic                 err_illegal,
    output logic                 err_align,
    output logic                 bus_valid,
    input  logic                 bus_ready,
    output logic [XLEN-1:0]      bus_addr,
    output logic                 bus_write,
    output logic [XLEN/8-1:0]    bus_strb,
    output logic [XLEN-1:0]      bus_wdata,
    output logic                 bus_priv,
    input  logic                 bus_rvalid,
    input  logic [XLEN-1:0]      bus_rdata,
    output logic                 done,
    output logic [XLEN-1:0]      rdata_out,
    output logic                 flag_we
);

    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    lsu_state_e state_q, state_d;

    logic              dec_illegal;
    acc_size_e         dec_size;
    logic              dec_sign;
    logic [XLEN-1:0]   ag_addr;
    logic [LANES-1:0]  ag_strb;
    logic [XLEN-1:0]   ag_wdata;
    logic              ag_misaligned;
    logic [XLEN-1:0]   ext_result;
    logic              accept;

    logic [XLEN-1:0]   addr_q;
    logic [LANES-1:0]  strb_q;
    logic [XLEN-1:0]   wdata_q;
    logic              write_q;
    logic              priv_q;
    acc_size_e         size_q;
    logic              sign_q;
    logic [XLEN-1:0]   result_q;

    uacc_decode_check #(
        .REG_IDX_W (REG_IDX_W)
    ) i_decode (
        .is_store (req_store),
        .kind     (req_kind),
        .rt_idx   (req_rt),
        .rn_idx   (req_rn),
        .illegal  (dec_illegal),
        .size     (dec_size),
        .sign_ext (dec_sign)
    );

    uacc_addr_gen #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) i_addr (
        .base       (req_base),
        .imm        (req_imm),
        .size       (dec_size),
        .wdata      (req_wdata),
        .addr       (ag_addr),
        .strb       (ag_strb),
        .lane_wdata (ag_wdata),
        .misaligned (ag_misaligned)
    );

    uacc_load_extend #(
        .XLEN (XLEN)
    ) i_extend (
        .rdata    (bus_rdata),
        .off      (addr_q[OFF_W-1:0]),
        .size     (size_q),
        .sign_ext (sign_q),
        .result   (ext_result)
    );

    assign accept = req_valid && (state_q == ST_IDLE) && !dec_illegal && !ag_misaligned;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)     state_d = ST_ADDR;
            ST_ADDR: if (bus_ready)  state_d = ST_RESP;
            ST_RESP: if (bus_rvalid) state_d = ST_DONE;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture and result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            strb_q   <= '0;
            wdata_q  <= '0;
            write_q  <= 1'b0;
            priv_q   <= 1'b0;
            size_q   <= SZ_WORD;
            sign_q   <= 1'b0;
            result_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= ag_addr;
                strb_q  <= ag_strb;
                wdata_q <= req_store ? ag_wdata : '0;
                write_q <= req_store;
                priv_q  <= core_priv && !user_override;
                size_q  <= dec_size;
                sign_q  <= dec_sign;
            end
            if ((state_q == ST_RESP) && bus_rvalid) begin
                result_q <= write_q ? '0 : ext_result;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        bus_valid   = 1'b0;
        done        = 1'b0;
        err_illegal = 1'b0;
        err_align   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready   = 1'b1;
                err_illegal = req_valid && dec_illegal;
                err_align   = req_valid && !dec_illegal && ag_misaligned;
            end
            ST_ADDR: bus_valid = 1'b1;
            ST_RESP: ;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign bus_addr  = addr_q;
    assign bus_strb  = strb_q;
    assign bus_wdata = wdata_q;
    assign bus_write = write_q;
    assign bus_priv  = priv_q;
    assign rdata_out = result_q;
    assign flag_we   = 1'b0;

endmodule

// File: rtl/uacc_checker.sv
module uacc_checker #(
    parameter int XLEN      = 32,
    parameter int REG_IDX_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [REG_IDX_W-1:0] req_rn,
    input logic [REG_IDX_W-1:0] req_rt,
    input logic                 user_override,
    input logic                 err_illegal,
    input logic                 err_align,
    input logic                 bus_valid,
    input logic                 bus_ready,
    input logic [XLEN-1:0]      bus_addr,
    input logic [XLEN/8-1:0]    bus_strb,
    input logic                 bus_priv,
    input logic                 done
);

    logic taken;
    assign taken = req_valid && req_ready && !err_illegal && !err_align;

    a_r5_override_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && user_override) |=> (bus_valid && !bus_priv));

    a_r6_pc_base: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_rn == 4'd15) |-> err_illegal);

    a_r7_bad_target: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_rt == 4'd13 || req_rt == 4'd15)) |-> err_illegal);

    a_r8_illegal_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal |=> !bus_valid);

    a_r9_align_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        err_align |=> !bus_valid);

    a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ready) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_strb) && $stable(bus_priv)));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    a_r12_ready_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !req_ready);

endmodule

bind user_access_lsu uacc_checker #(
    .XLEN      (XLEN),
    .REG_IDX_W (REG_IDX_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_rn        (req_rn),
    .req_rt        (req_rt),
    .user_override (user_override),
    .err_illegal   (err_illegal),
    .err_align     (err_align),
    .bus_valid     (bus_valid),
    .bus_ready     (bus_ready),
    .bus_addr      (bus_addr),
    .bus_strb      (bus_strb),
    .bus_priv      (bus_priv),
    .done          (done)
);

// File: tb/test_user_access_lsu.sv
`timescale 1ns/1ps
module test_user_access_lsu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_store = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [3:0]  req_rn = 4'd0;
    logic [3:0]  req_rt = 4'd0;
    logic [31:0] req_base = '0;
    logic [7:0]  req_imm = '0;
    logic [31:0] req_wdata = '0;
    logic        core_priv = 1'b0;
    logic        user_override = 1'b0;
    logic        err_illegal, err_align;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic [31:0] bus_addr;
    logic        bus_write;
    logic [3:0]  bus_strb;
    logic [31:0] bus_wdata;
    logic        bus_priv;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        done;
    logic [31:0] rdata_out;
    logic        flag_we;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    user_access_lsu i_user_access_lsu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_kind(req_kind), .req_rn(req_rn), .req_rt(req_rt),
        .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
        .core_priv(core_priv), .user_override(user_override),
        .err_illegal(err_illegal), .err_align(err_align),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
        .bus_priv(bus_priv), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .done(done), .rdata_out(rdata_out), .flag_we(flag_we)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    function automatic bit exp_illegal(bit st, int kind, int rt, int rn);
        return (rn == 15) || (rt == 13) || (rt == 15) || (kind > 4) ||
               (st && (kind == 1 || kind == 3));
    endfunction

    function automatic logic [31:0] exp_load(int kind, logic [31:0] rd, int off);
        logic [31:0] v;
        v = rd >> (8 * off);
        case (kind)
            0: v = v & 32'hFF;
            1: begin v = v & 32'hFF; if (v >= 128) v = v + 32'hFFFFFF00; end
            2: v = v & 32'hFFFF;
            3: begin v = v & 32'hFFFF; if (v >= 32768) v = v + 32'hFFFF0000; end
            default: ;
        endcase
        return v;
    endfunction

    task automatic run_access(input bit st, input int kind, input logic [31:0] base,
                              input int imm, input int rt, input int rn,
                              input logic [31:0] wd, input bit priv, input bit ovr,
                              input logic [31:0] rresp, input int stall);
        logic [31:0] e_addr, e_wd, e_res;
        logic [3:0]  e_strb;
        int          off, sz;
        bit          e_ill, e_mis, e_priv;
        e_addr = base + 32'(imm);
        off    = int'(e_addr[1:0]);
        sz     = (kind <= 1) ? 1 : (kind <= 3) ? 2 : 4;
        e_ill  = exp_illegal(st, kind, rt, rn);
        e_mis  = !e_ill && (off % sz != 0);
        e_priv = priv && !ovr;
        e_strb = (sz == 1) ? 4'(1 << off) : (sz == 2) ? 4'(3 << off) : 4'hF;
        e_wd   = (sz == 1) ? wd[7:0] * 32'h01010101 :
                 (sz == 2) ? wd[15:0] * 32'h00010001 : wd;
        e_res  = st ? 32'h0 : exp_load(kind, rresp, off);

        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_kind = 3'(kind); req_base = base;
        req_imm = 8'(imm); req_rt = 4'(rt); req_rn = 4'(rn); req_wdata = wd;
        core_priv = priv; user_override = ovr;
        #0.5;
        chk(err_illegal == e_ill, "R8 err_illegal (R1 R2 R6 R7)", 32'(err_illegal), 32'(e_ill));
        chk(err_align == e_mis, "R9 err_align", 32'(err_align), 32'(e_mis));
        chk(flag_we == 1'b0, "R11 flag_we", 32'(flag_we), 0);
        @(negedge clk);
        req_valid = 1'b0;
        if (e_ill || e_mis) begin
            chk(!bus_valid, "R8 R9 no transfer", 32'(bus_valid), 0);
            @(negedge clk);
            chk(!bus_valid && req_ready, "R8 R9 stays idle", 32'(bus_valid), 0);
            return;
        end
        chk(bus_valid && !req_ready, "R12 busy request", {30'd0, bus_valid, req_ready}, 32'h2);
        chk(bus_addr == e_addr, "R3 address", bus_addr, e_addr);
        chk(bus_strb == e_strb, "R4 strobes", 32'(bus_strb), 32'(e_strb));
        chk(bus_write == st, "R4 write", 32'(bus_write), 32'(st));
        chk(bus_priv == e_priv, "R5 privilege", 32'(bus_priv), 32'(e_priv));
        if (st) chk(bus_wdata == e_wd, "R4 store data", bus_wdata, e_wd);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            chk(bus_valid && bus_addr == e_addr && bus_strb == e_strb,
                "R10 hold while stalled", bus_addr, e_addr);
        end
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        chk(!bus_valid && !done, "R10 request dropped", 32'(bus_valid), 0);
        bus_rvalid = 1'b1; bus_rdata = rresp;
        @(negedge clk);
        bus_rvalid = 1'b0; bus_rdata = 32'hDEAD_BEEF;
        chk(done == 1'b1, "R10 done pulse", 32'(done), 1);
        chk(rdata_out == e_res, "R1 R10 load result", rdata_out, e_res);
        @(negedge clk);
        chk(!done && req_ready, "R12 back to idle", {30'd0, done, req_ready}, 32'h1);
        chk(flag_we == 1'b0, "R11 flag_we", 32'(flag_we), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !bus_valid && !done, "R12 reset state",
            {29'd0, req_ready, bus_valid, done}, 32'h4);
        chk(flag_we == 1'b0, "R11 reset flag_we", 32'(flag_we), 0);

        // R1 R9: every kind at every offset, two data patterns
        for (int p = 0; p < 2; p++)
            for (int kd = 0; kd < 5; kd++)
                for (int of = 0; of < 4; of++)
                    run_access(1'b0, kd, 32'h1234_5670, 16 + of, 1, 2, '0, 1'b1, 1'b0,
                               (p == 0) ? 32'h8F7E_A59C : 32'h7F80_017F, of % 2);

        // R4: stores of each unsigned size at each offset
        for (int kd = 0; kd < 5; kd += 2)
            for (int of = 0; of < 4; of++)
                run_access(1'b1, kd, 32'h0000_8000, of, 3, 4, 32'hC3A5_5A3C, 1'b1, 1'b0, '0, 0);

        // R5: privilege and override combinations
        for (int pv = 0; pv < 2; pv++)
            for (int ov = 0; ov < 2; ov++) begin
                run_access(1'b0, 4, 32'h2000_0000, 8, 5, 6, '0, 1'(pv), 1'(ov), 32'h1111_2222, 1);
                run_access(1'b1, 0, 32'h2000_0000, 9, 5, 6, 32'h77, 1'(pv), 1'(ov), '0, 0);
            end

        // R6 R7: register index sweeps
        for (int r = 0; r < 16; r++) begin
            run_access(1'b0, 4, 32'h3000_0000, 4, 0, r, '0, 1'b0, 1'b0, 32'h55AA_55AA, 0);
            run_access(1'b1, 4, 32'h3000_0000, 4, r, 0, 32'h1, 1'b0, 1'b0, '0, 0);
        end

        // R2: signed kinds on stores; R1: undefined kinds
        run_access(1'b1, 1, 32'h4000_0000, 0, 1, 1, 32'hFF, 1'b1, 1'b0, '0, 0);
        run_access(1'b1, 3, 32'h4000_0000, 0, 1, 1, 32'hFF, 1'b1, 1'b0, '0, 0);
        for (int kd = 5; kd < 8; kd++)
            run_access(1'b0, kd, 32'h4000_0000, 0, 1, 1, '0, 1'b1, 1'b0, '0, 0);

        // R3: zero offset, maximum offset, wrap around
        run_access(1'b0, 4, 32'h0000_1000, 0, 2, 2, '0, 1'b0, 1'b0, 32'hCAFE_F00D, 0);
        run_access(1'b0, 0, 32'hFFFF_FFF0, 255, 2, 2, '0, 1'b0, 1'b0, 32'h0102_0304, 2);
        run_access(1'b0, 4, 32'hFFFF_FF04, 252, 2, 2, '0, 1'b0, 1'b0, 32'h0A0B_0C0D, 0);

        // R10: long stall
        run_access(1'b0, 3, 32'h5000_0002, 0, 7, 8, '0, 1'b1, 1'b1, 32'h8001_0000, 5);

        summary();
        $finish;
    end

endmodule